// File: doc/BRIEF.md
# Paged Address Translator with Translation Cache

This block turns a 14-bit virtual address into a 12-bit physical address for a core that uses 64-byte pages. The low six address bits are the offset within the page and are not translated. The upper eight bits form the virtual page number (VPN). The block maps each VPN to a six-bit physical page number (PPN). Recent mappings are kept in a 16-entry translation cache, organised as 4 sets of 4 ways. The two low VPN bits choose the set, and the six upper VPN bits are stored as the tag.

A lookup that hits in the cache completes without touching memory. On a miss, the block makes one read of a single-level table in memory. The table has one entry per VPN, and the entry's address is the table base input plus the VPN. A valid entry that comes back is written into the cache, and the lookup is then repeated and hits. An invalid entry ends the request with a page fault. Every mapping carries read, write and supervisor-only permission bits. Each response reports a protection fault when the access breaks one of them.

The block handles one request at a time, using a five-state controller:
- IDLE accepts a request and moves to LOOKUP.
- LOOKUP goes to RESP on a hit and to WALK on a miss.
- WALK drives the table read for one cycle and moves to WAIT.
- WAIT stays until the read data returns. It then goes to LOOKUP if the entry is valid and to RESP if it is not.
- RESP presents the result for one cycle and returns to IDLE.

A flush input empties the cache. It is used when the table base changes.

Top module: `mmu_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, and `rsp_valid` and `pt_req_valid` are 0. The cache is empty, so the first request to any page makes a table read.
- R2: A response without a fault gives `rsp_pa` = {PPN, `req_va[5:0]`}.
- R3: A request that hits in the cache makes no table read. Its `rsp_valid` is seen in the second cycle after the cycle in which the request was accepted.
- R4: A miss makes exactly one table read, a one-cycle `pt_req_valid` pulse with `pt_req_addr` = `ptbr` + VPN, in the cycle after the lookup. The table data is assumed to arrive at least one cycle later. With the data in the cycle after the read, a miss to a valid entry responds in the fifth cycle after acceptance.
- R5: The table entry is 10 bits: bit 9 valid, bit 8 supervisor-only, bit 7 write allowed, bit 6 read allowed, and bits 5:0 the PPN.
  - An entry with bit 9 clear gives a response in the fourth cycle after acceptance with `rsp_page_fault` = 1, `rsp_prot_fault` = 0 and `rsp_pa` = 0.
  - Such an entry is not cached, so repeating the request reads the table again.
  - Page fault and protection fault are never both 1.
- R6: A valid entry that is fetched goes into set VPN[1:0], in the lowest-numbered empty way. If the set is full, it replaces the way named by that set's round-robin pointer, which starts at way 0 and advances by one after each replacement in a full set.
- R7: A protection fault is raised, with `rsp_pa` = 0, in three cases:
  - a write to a page with bit 7 clear;
  - a read from a page with bit 6 clear;
  - an access with `req_sup` = 0 to a page with bit 8 set.

  The same rule applies whether the mapping came from the cache or from a fresh table read.
- R8: `req_ready` is 0 from the cycle after a request is accepted until the response cycle has ended.
- R9: A one-cycle `flush` pulse empties every cache entry, so the next request to a page that was cached misses.
- R10: `rsp_valid` is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all cached mappings |
| ptbr | input | 12 | Base address of the page table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_va | input | 14 | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_sup | input | 1 | Requester is in supervisor mode |
| rsp_valid | output | 1 | Result valid (one cycle) |
| rsp_pa | output | 12 | Physical address, 0 on any fault |
| rsp_page_fault | output | 1 | Mapping not present |
| rsp_prot_fault | output | 1 | Permission violation |
| pt_req_valid | output | 1 | Page-table read request (one-cycle pulse) |
| pt_req_addr | output | 12 | Page-table entry address |
| pt_rsp_valid | input | 1 | Page-table read data valid |
| pt_rsp_pte | input | 10 | Page-table entry |

## Verification
The assertions check, on every cycle, the properties visible at the edges of the block:
- the result and the table read are single-cycle pulses;
- no request is accepted while a result or a table read is pending;
- a table read goes to the base plus the VPN of the accepted address;
- a clean result keeps the page offset;
- a faulting result carries a zero address and never both fault flags.

Other behaviours show only through the bench's scenarios:
- whether an access hits or misses, seen from its latency and table-read count;
- the way a full set chooses its victim;
- the refusal to cache invalid entries;
- the effect of a flush;
- each permission combination.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
    localparam int VA_W  = 14;
    localparam int PA_W  = 12;
    localparam int OFS_W = 6;
    localparam int VPN_W = VA_W - OFS_W;
    localparam int PPN_W = PA_W - OFS_W;
    localparam int SETS  = 4;
    localparam int WAYS  = 4;
    localparam int SET_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int TAG_W = VPN_W - SET_W;

    // Page-table entry layout: valid, supervisor-only, write, read, page number
    typedef struct packed {
        logic             vld;
        logic             sup;
        logic             wr;
        logic             rd;
        logic [PPN_W-1:0] ppn;
    } pte_t;

    localparam int PTE_W = $bits(pte_t);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_WALK,
        ST_WAIT,
        ST_RESP
    } xl_state_e;
endpackage

// File: rtl/mmu_perm.sv
module mmu_perm (
    input  logic pg_rd,
    input  logic pg_wr,
    input  logic pg_sup,
    input  logic is_write,
    input  logic is_sup,
    output logic prot_fault
);
    logic type_bad;
    logic mode_bad;

    always_comb begin
        type_bad   = is_write ? !pg_wr : !pg_rd;
        mode_bad   = pg_sup && !is_sup;
        prot_fault = type_bad || mode_bad;
    end
endmodule

// File: rtl/mmu_tlb.sv
module mmu_tlb
    import mmu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output pte_t             lk_pte,
    input  logic             ins_en,
    input  logic [VPN_W-1:0] ins_vpn,
    input  pte_t             ins_pte
);
    logic [WAYS-1:0]  vld_q [SETS];
    logic [TAG_W-1:0] tag_q [SETS][WAYS];
    pte_t             ent_q [SETS][WAYS];
    logic [WAY_W-1:0] rr_q  [SETS];

    logic [SET_W-1:0] lk_set;
    logic [SET_W-1:0] in_set;
    logic [TAG_W-1:0] lk_tag;
    logic [TAG_W-1:0] in_tag;
    logic [WAYS-1:0]  match;
    logic [WAY_W-1:0] victim;
    logic             set_full;

    assign lk_set = lk_vpn[SET_W-1:0];
    assign lk_tag = lk_vpn[VPN_W-1:SET_W];
    assign in_set = ins_vpn[SET_W-1:0];
    assign in_tag = ins_vpn[VPN_W-1:SET_W];

    genvar w;
    generate
        for (w = 0; w < WAYS; w++) begin : g_way
            assign match[w] = vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
        end
    endgenerate

    assign lk_hit = |match;

    always_comb begin
        lk_pte = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (match[i]) lk_pte = ent_q[lk_set][i];
        end
    end

    // lowest empty way, else the set's rotating pointer
    always_comb begin
        victim   = rr_q[in_set];
        set_full = 1'b1;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!vld_q[in_set][i]) begin
                victim   = WAY_W'(i);
                set_full = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld_q[s] <= '0;
                rr_q[s]  <= '0;
            end
        end else if (flush) begin
            for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
        end else if (ins_en) begin
            vld_q[in_set][victim] <= 1'b1;
            if (set_full) rr_q[in_set] <= rr_q[in_set] + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (ins_en) begin
            tag_q[in_set][victim] <= in_tag;
            ent_q[in_set][victim] <= ins_pte;
        end
    end
endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate
    import mmu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [PA_W-1:0]  ptbr,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_va,
    input  logic             req_write,
    input  logic             req_sup,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_pa,
    output logic             rsp_page_fault,
    output logic             rsp_prot_fault,
    output logic             pt_req_valid,
    output logic [PA_W-1:0]  pt_req_addr,
    input  logic             pt_rsp_valid,
    input  logic [PTE_W-1:0] pt_rsp_pte
);
    xl_state_e state_q, state_d;

    logic [VA_W-1:0] va_q;
    logic            wr_q;
    logic            sup_q;
    logic [PA_W-1:0] pa_q;
    logic            pf_q;
    logic            prot_q;

    logic [VPN_W-1:0] vpn;
    logic [OFS_W-1:0] ofs;
    logic             lk_hit;
    pte_t             lk_pte;
    pte_t             walk_pte;
    logic             hit_ok;
    logic             ins_en;
    logic             prot_bad;

    assign vpn      = va_q[VA_W-1:OFS_W];
    assign ofs      = va_q[OFS_W-1:0];
    assign walk_pte = pte_t'(pt_rsp_pte);
    assign hit_ok   = lk_hit && lk_pte.vld;

    mmu_tlb u_tlb (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .lk_vpn  (vpn),
        .lk_hit  (lk_hit),
        .lk_pte  (lk_pte),
        .ins_en  (ins_en),
        .ins_vpn (vpn),
        .ins_pte (walk_pte)
    );

    mmu_perm u_perm (
        .pg_rd      (lk_pte.rd),
        .pg_wr      (lk_pte.wr),
        .pg_sup     (lk_pte.sup),
        .is_write   (wr_q),
        .is_sup     (sup_q),
        .prot_fault (prot_bad)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_LOOKUP;
            ST_LOOKUP: state_d = hit_ok ? ST_RESP : ST_WALK;
            ST_WALK:   state_d = ST_WAIT;
            ST_WAIT:   if (pt_rsp_valid) state_d = walk_pte.vld ? ST_LOOKUP : ST_RESP;
            ST_RESP:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        req_ready    = (state_q == ST_IDLE);
        rsp_valid    = (state_q == ST_RESP);
        pt_req_valid = (state_q == ST_WALK);
        ins_en       = (state_q == ST_WAIT) && pt_rsp_valid && walk_pte.vld;
        pt_req_addr  = ptbr + PA_W'(vpn);
    end

    assign rsp_pa         = pa_q;
    assign rsp_page_fault = pf_q;
    assign rsp_prot_fault = prot_q;

    // request capture and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q   <= '0;
            wr_q   <= 1'b0;
            sup_q  <= 1'b0;
            pa_q   <= '0;
            pf_q   <= 1'b0;
            prot_q <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                va_q  <= req_va;
                wr_q  <= req_write;
                sup_q <= req_sup;
            end
            if (state_q == ST_LOOKUP && hit_ok) begin
                pf_q   <= 1'b0;
                prot_q <= prot_bad;
                pa_q   <= prot_bad ? '0 : {lk_pte.ppn, ofs};
            end
            if (state_q == ST_WAIT && pt_rsp_valid && !walk_pte.vld) begin
                pf_q   <= 1'b1;
                prot_q <= 1'b0;
                pa_q   <= '0;
            end
        end
    end
endmodule

// File: rtl/mmu_xlate_chk.sv
module mmu_xlate_chk
    import mmu_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic [PA_W-1:0] ptbr,
    input logic            req_valid,
    input logic            req_ready,
    input logic [VA_W-1:0] req_va,
    input logic            rsp_valid,
    input logic [PA_W-1:0] rsp_pa,
    input logic            rsp_page_fault,
    input logic            rsp_prot_fault,
    input logic            pt_req_valid,
    input logic [PA_W-1:0] pt_req_addr
);
    logic [VA_W-1:0] cap_va;

    always_ff @(posedge clk) begin
        if (!rst_n)                      cap_va <= '0;
        else if (req_valid && req_ready) cap_va <= req_va;
    end

    assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_busy_rsp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    assert_busy_walk_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pt_req_valid |-> !req_ready);

    assert_walk_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pt_req_valid |=> !pt_req_valid);

    assert_walk_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pt_req_valid |-> (pt_req_addr == ptbr + PA_W'(cap_va[VA_W-1:OFS_W])));

    assert_offset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_page_fault && !rsp_prot_fault) |-> (rsp_pa[OFS_W-1:0] == cap_va[OFS_W-1:0]));

    assert_fault_zero_pa_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_page_fault || rsp_prot_fault)) |-> (rsp_pa == '0));

    assert_fault_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !(rsp_page_fault && rsp_prot_fault));
endmodule

bind mmu_xlate mmu_xlate_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ptbr           (ptbr),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_va         (req_va),
    .rsp_valid      (rsp_valid),
    .rsp_pa         (rsp_pa),
    .rsp_page_fault (rsp_page_fault),
    .rsp_prot_fault (rsp_prot_fault),
    .pt_req_valid   (pt_req_valid),
    .pt_req_addr    (pt_req_addr)
);

// File: tb/mmu_xlate_test.sv
module mmu_xlate_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic [11:0] ptbr = 12'h100;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [13:0] req_va = '0;
    logic        req_write = 1'b0;
    logic        req_sup = 1'b0;
    logic        rsp_valid;
    logic [11:0] rsp_pa;
    logic        rsp_page_fault;
    logic        rsp_prot_fault;
    logic        pt_req_valid;
    logic [11:0] pt_req_addr;
    logic        pt_rsp_valid = 1'b0;
    logic [9:0]  pt_rsp_pte = '0;

    int nchk = 0;
    int nfail = 0;
    int nreq = 0;
    logic [11:0] last_addr = '0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mmu_xlate uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .flush          (flush),
        .ptbr           (ptbr),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_va         (req_va),
        .req_write      (req_write),
        .req_sup        (req_sup),
        .rsp_valid      (rsp_valid),
        .rsp_pa         (rsp_pa),
        .rsp_page_fault (rsp_page_fault),
        .rsp_prot_fault (rsp_prot_fault),
        .pt_req_valid   (pt_req_valid),
        .pt_req_addr    (pt_req_addr),
        .pt_rsp_valid   (pt_rsp_valid),
        .pt_rsp_pte     (pt_rsp_pte)
    );

    // page-table contents as a function of entry address: {vld,sup,wr,rd,ppn}
    function automatic logic [9:0] pte_at(logic [11:0] a);
        logic [7:0] v;
        logic [5:0] p;
        v = a[7:0];
        p = v[5:0] ^ {2'b00, a[11:8]};
        if (v == 8'h0F) return {4'b1011, 6'h0D};
        if (v == 8'h00) return {4'b1011, 6'h28};
        if (v == 8'h2E) return 10'h000;
        case (v[7:6])
            2'b00:   return {1'b1, 1'b0, 1'b1, 1'b1, p};
            2'b01:   return {1'b1, 1'b0, 1'b0, ~v[0], p};
            2'b10:   return {1'b1, 1'b1, 1'b1, 1'b1, p};
            default: return 10'h000;
        endcase
    endfunction

    // page-table memory: data one cycle after the read pulse
    initial begin
        bit pend;
        pend = 0;
        forever begin
            @(negedge clk);
            if (pt_rsp_valid) pt_rsp_valid = 1'b0;
            if (pt_req_valid) begin
                last_addr = pt_req_addr;
                nreq++;
                pend = 1;
            end else if (pend) begin
                pt_rsp_pte   = pte_at(last_addr);
                pt_rsp_valid = 1'b1;
                pend = 0;
            end
        end
    end

    task automatic chk(input string rq, input int act, input int exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
        end
    endtask

    task automatic run(input logic [13:0] va, input logic wr, input logic sup,
                       input logic [11:0] epa, input logic epf, input logic eprot,
                       input int elat, input string rq);
        int lat;
        int n0;
        n0 = nreq;
        req_va = va;
        req_write = wr;
        req_sup = sup;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        chk("R8", int'(req_ready), 0);
        while (!rsp_valid && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        chk(rq, lat, elat);
        chk(rq, nreq - n0, (elat > 2) ? 1 : 0);
        chk("R2", int'(rsp_pa), int'(epa));
        chk("R5", int'(rsp_page_fault), int'(epf));
        chk("R7", int'(rsp_prot_fault), int'(eprot));
        if (elat > 2) chk("R4", int'(last_addr), int'(ptbr + {4'h0, va[13:6]}));
        @(negedge clk);
        chk("R10", int'(rsp_valid), 0);
    endtask

    // {va[14], write, sup, page_fault, prot_fault, pa[12], latency[4]}
    localparam logic [33:0] VEC [0:12] = '{
        {14'h03D4, 1'b0, 1'b0, 1'b0, 1'b0, 12'h354, 4'd5},
        {14'h03D4, 1'b0, 1'b0, 1'b0, 1'b0, 12'h354, 4'd2},
        {14'h0B8F, 1'b0, 1'b0, 1'b1, 1'b0, 12'h000, 4'd4},
        {14'h0B8F, 1'b0, 1'b0, 1'b1, 1'b0, 12'h000, 4'd4},
        {14'h0020, 1'b0, 1'b0, 1'b0, 1'b0, 12'hA20, 4'd5},
        {14'h0020, 1'b1, 1'b0, 1'b0, 1'b0, 12'hA20, 4'd2},
        {14'h1045, 1'b0, 1'b0, 1'b0, 1'b1, 12'h000, 4'd5},
        {14'h103F, 1'b1, 1'b0, 1'b0, 1'b1, 12'h000, 4'd5},
        {14'h103F, 1'b0, 1'b0, 1'b0, 1'b0, 12'h07F, 4'd2},
        {14'h2011, 1'b0, 1'b0, 1'b0, 1'b1, 12'h000, 4'd5},
        {14'h2011, 1'b0, 1'b1, 1'b0, 1'b0, 12'h051, 4'd2},
        {14'h2011, 1'b1, 1'b1, 1'b0, 1'b0, 12'h051, 4'd2},
        {14'h3140, 1'b0, 1'b0, 1'b1, 1'b0, 12'h000, 4'd4}
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", int'(req_ready), 1);
        chk("R1", int'(rsp_valid), 0);
        chk("R1", int'(pt_req_valid), 0);

        // vector table: reference translations, faults, permissions (R3 R4 R5 R7)
        for (int i = 0; i < 13; i++) begin
            logic [33:0] v;
            v = VEC[i];
            run(v[33:20], v[19], v[18], v[15:4], v[17], v[16], int'(v[3:0]),
                (v[3:0] == 4'd2) ? "R3" : "R4");
        end

        // R6 set 0 holds VPN 00,40,80; fill and overflow it
        run(14'h0100, 1'b0, 1'b0, 12'h140, 1'b0, 1'b0, 5, "R6");
        run(14'h0200, 1'b0, 1'b0, 12'h240, 1'b0, 1'b0, 5, "R6");
        run(14'h1000, 1'b0, 1'b0, 12'h040, 1'b0, 1'b0, 2, "R6");
        run(14'h0000, 1'b0, 1'b0, 12'hA00, 1'b0, 1'b0, 5, "R6");
        run(14'h1000, 1'b0, 1'b0, 12'h040, 1'b0, 1'b0, 5, "R6");
        run(14'h0100, 1'b0, 1'b0, 12'h140, 1'b0, 1'b0, 2, "R6");

        // R9 flush empties the cache
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        run(14'h03D4, 1'b0, 1'b0, 12'h354, 1'b0, 1'b0, 5, "R9");

        // R9 new table base with flush
        ptbr  = 12'h200;
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        run(14'h0140, 1'b0, 1'b0, 12'h1C0, 1'b0, 1'b0, 5, "R9");
        chk("R4", int'(last_addr), 12'h205);
        run(14'h0140, 1'b0, 1'b0, 12'h1C0, 1'b0, 1'b0, 2, "R3");

        chk("R8", int'(req_ready), 1);
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end
endmodule